// File: doc/BRIEF.md
# Disk-Function Interrupt Cause Controller

This block keeps the interrupt state for the disk function of an I/O chip. Two causes are tracked: a device interrupt and a bus error seen by the DMA engine. Each cause has a pending bit and an enable bit. The host sees a single level interrupt. It is asserted while any cause is both pending and enabled. When a DMA bus error is first recorded, its 64-bit bus address is captured and made readable as two 32-bit words.

Software reaches the block through a word-indexed register port. A status word shows the pending causes. A set word turns enables on. A clear word drops pending causes when 1s are written to it. The block also watches reads of the attached device's status byte. A read made while the device is not busy clears every pending cause as a side effect. Host bus decode and the DMA engine lie outside the block: the engine is represented by an error strobe that carries an address.

Top module: `irq_cause_ctrl`

## Requirements
- R1: After reset, pending and enable bits are 0, the captured address is 0, `irq_o` is 0 and `rdata_o` is 0.
- R2: A pulse on `dev_irq_i` sets pending bit 0 and a pulse on `dma_err_i` sets pending bit 1. The status word, at index 3, returns the pending bits in bits [1:0] and 0 in all other bits.
- R3: A write to index 5 sets each enable bit whose data bit is 1. Data bits that are 0 leave the enable unchanged. Reading index 5 returns the enables in bits [1:0].
- R4: A write to index 7 clears each pending bit whose data bit is 1. Data bits that are 0 leave the pending bit unchanged.
- R5: When a cause event and a clear of the same bit fall in one cycle, the bit is pending afterwards. This applies to a clear write and to a non-busy status read.
- R6: `irq_o` is 1 exactly when some cause is both pending and enabled. It follows the register state with no added delay.
- R7: A device status read (`stat_rd_i`) with `dev_stat_i` bit 7 equal to 0 clears all pending bits. With bit 7 equal to 1 it has no effect.
- R8: On a DMA error, `dma_err_addr_i` is captured if bit 1 is not pending, or if bit 1 is being cleared in the same cycle. Index 0 returns address bits [31:0] and index 1 returns bits [63:32].
- R9: DMA errors that arrive while bit 1 stays pending leave the captured address unchanged.
- R10: A read request returns data on `rdata_o` one cycle later. The data reflects the state before that same edge. `rdata_o` holds its value between reads. Indices 2, 4, 6 and 7 read 0. Writes to indices 0, 1 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (3) | Word index |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Registered read data |
| dev_irq_i | input | 1 | Device interrupt event |
| dma_err_i | input | 1 | DMA bus-error event |
| dma_err_addr_i | input | 2*DATA_W (64) | Bus address of the error |
| stat_rd_i | input | 1 | Device status byte is being read |
| dev_stat_i | input | STAT_W (8) | Device status byte; bit 7 = busy |
| irq_o | output | 1 | Level interrupt to host |

## Verification
Two actions can fall in the same cycle: a cause event and a clear of the same bit. The clear comes either from a write to the clear word or from a non-busy device status read. The bench provokes both orderings. It pulses `dma_err_i` in the cycle of a clear write. It pulses `dev_irq_i` in the cycle of a non-busy status read. In both cases the bit must stay pending, and after the error case the address must be the newly captured one. A behavioural reference model follows every cycle, and `irq_o` and `rdata_o` are compared against it on each clock.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int IDX_ERR_LO  = 0;
  localparam int IDX_ERR_HI  = 1;
  localparam int IDX_STATUS  = 3;
  localparam int IDX_EN_SET  = 5;
  localparam int IDX_CLEAR   = 7;
  localparam int N_CAUSE     = 2;
  localparam int CAUSE_DEV   = 0;
  localparam int CAUSE_BUSERR = 1;
endpackage

// File: rtl/irqc_cause_cell.sv
module irqc_cause_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic clr_i,
  input  logic en_set_i,
  output logic pend_o,
  output logic en_o
);
  logic pend_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~clr_i) | evt_i;  // event wins over clear
      en_q   <= en_q | en_set_i;
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;

  p_evt_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> pend_o);
  p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !evt_i) |=> !pend_o);
  p_en_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o |=> en_o);
endmodule

// File: rtl/irqc_err_capture.sv
module irqc_err_capture #(
  parameter int ADDR_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              err_i,
  input  logic [ADDR_W-1:0] err_addr_i,
  input  logic              pend_i,
  input  logic              clr_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;
  logic              cap;

  assign cap = err_i && (!pend_i || clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  addr_q <= '0;
    else if (cap) addr_q <= err_addr_i;
  end

  assign addr_o = addr_q;

  p_addr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i && !clr_i) |=> $stable(addr_o));
  p_first_capture_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i && !pend_i) |=> (addr_o == $past(err_addr_i)));
endmodule

// File: rtl/irqc_rd_mux.sv
module irqc_rd_mux
  import irqc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rd_i,
  input  logic [ADDR_W-1:0]   idx_i,
  input  logic [N_CAUSE-1:0]  pend_i,
  input  logic [N_CAUSE-1:0]  en_i,
  input  logic [2*DATA_W-1:0] err_addr_i,
  output logic [DATA_W-1:0]   rdata_o
);
  logic [DATA_W-1:0] sel, rdata_q;

  always_comb begin
    sel = '0;
    if (idx_i == ADDR_W'(IDX_ERR_LO))      sel = err_addr_i[DATA_W-1:0];
    else if (idx_i == ADDR_W'(IDX_ERR_HI)) sel = err_addr_i[2*DATA_W-1:DATA_W];
    else if (idx_i == ADDR_W'(IDX_STATUS)) sel = DATA_W'(pend_i);
    else if (idx_i == ADDR_W'(IDX_EN_SET)) sel = DATA_W'(en_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= sel;
  end

  assign rdata_o = rdata_q;

  p_rd_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
  p_status_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && idx_i == ADDR_W'(IDX_STATUS)) |=> (rdata_o == DATA_W'($past(pend_i))));
endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
  import irqc_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 3,
  parameter int STAT_W   = 8,
  parameter int BUSY_BIT = 7
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic                dev_irq_i,
  input  logic                dma_err_i,
  input  logic [2*DATA_W-1:0] dma_err_addr_i,
  input  logic                stat_rd_i,
  input  logic [STAT_W-1:0]   dev_stat_i,
  output logic                irq_o
);
  localparam int EA_W = 2 * DATA_W;

  logic               wr_clear, wr_enset, rd_req, idle_stat_rd;
  logic [N_CAUSE-1:0] evt_vec, clr_vec, enset_vec, pend_vec, en_vec;
  logic [EA_W-1:0]    err_addr;

  assign wr_clear     = req_i && we_i && (addr_i == ADDR_W'(IDX_CLEAR));
  assign wr_enset     = req_i && we_i && (addr_i == ADDR_W'(IDX_EN_SET));
  assign rd_req       = req_i && !we_i;
  assign idle_stat_rd = stat_rd_i && !dev_stat_i[BUSY_BIT];

  always_comb begin
    evt_vec = '0;
    evt_vec[CAUSE_DEV]    = dev_irq_i;
    evt_vec[CAUSE_BUSERR] = dma_err_i;
  end

  assign clr_vec   = (wr_clear ? wdata_i[N_CAUSE-1:0] : '0) | {N_CAUSE{idle_stat_rd}};
  assign enset_vec = wr_enset ? wdata_i[N_CAUSE-1:0] : '0;

  for (genvar c = 0; c < N_CAUSE; c++) begin : g_cause
    irqc_cause_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .evt_i    (evt_vec[c]),
      .clr_i    (clr_vec[c]),
      .en_set_i (enset_vec[c]),
      .pend_o   (pend_vec[c]),
      .en_o     (en_vec[c])
    );
  end

  irqc_err_capture #(.ADDR_W(EA_W)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .err_i      (dma_err_i),
    .err_addr_i (dma_err_addr_i),
    .pend_i     (pend_vec[CAUSE_BUSERR]),
    .clr_i      (clr_vec[CAUSE_BUSERR]),
    .addr_o     (err_addr)
  );

  irqc_rd_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_i       (rd_req),
    .idx_i      (addr_i),
    .pend_i     (pend_vec),
    .en_i       (en_vec),
    .err_addr_i (err_addr),
    .rdata_o    (rdata_o)
  );

  assign irq_o = |(pend_vec & en_vec);

  p_idle_read_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_stat_rd && !dev_irq_i && !dma_err_i) |=> (pend_vec == '0));
  p_busy_read_noop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && dev_stat_i[BUSY_BIT] && !req_i && !dev_irq_i && !dma_err_i)
      |=> $stable(pend_vec));
  p_irq_needs_enable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (en_vec != '0) && (pend_vec != '0));
endmodule

// File: tb/irq_cause_ctrl_tb_top.sv
module irq_cause_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 0, we = 0, dev_irq = 0, dma_err = 0, stat_rd = 0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [63:0] eaddr = '0;
  logic [7:0]  stat = '0;
  logic [31:0] rdata;
  logic        irq;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  irq_cause_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .dev_irq_i(dev_irq), .dma_err_i(dma_err),
    .dma_err_addr_i(eaddr), .stat_rd_i(stat_rd), .dev_stat_i(stat), .irq_o(irq)
  );

  // behavioural reference model
  bit [1:0]  m_pend, m_en;
  bit [63:0] m_addr;
  bit [31:0] m_rdata;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = 0; m_en = 0; m_addr = 0; m_rdata = 0;
    end else begin
      bit [1:0] clr;
      bit [1:0] evt;
      clr = 0;
      if (req && we && addr == 3'd7) clr = wdata[1:0];
      if (stat_rd && stat[7] == 1'b0) clr = 2'b11;
      evt = {dma_err, dev_irq};
      if (req && !we) begin
        case (addr)
          3'd0: m_rdata = m_addr[31:0];
          3'd1: m_rdata = m_addr[63:32];
          3'd3: m_rdata = {30'd0, m_pend};
          3'd5: m_rdata = {30'd0, m_en};
          default: m_rdata = 0;
        endcase
      end
      if (dma_err && (m_pend[1] == 1'b0 || clr[1])) m_addr = eaddr;
      m_pend = (m_pend & ~clr) | evt;
      if (req && we && addr == 3'd5) m_en = m_en | wdata[1:0];
    end
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check("R6 irq_o", 64'(irq), 64'(|(m_pend & m_en)));
      check("R10 rdata_o", 64'(rdata), 64'(m_rdata));
    end
  end

  task automatic step(bit r, bit w, bit [2:0] a, bit [31:0] d,
                      bit di, bit de, bit [63:0] ea, bit sr, bit [7:0] st);
    @(negedge clk);
    req = r; we = w; addr = a; wdata = d; dev_irq = di; dma_err = de;
    eaddr = ea; stat_rd = sr; stat = st;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic rd(bit [2:0] a, output logic [31:0] v);
    step(1, 0, a, 0, 0, 0, 0, 0, 0);
    idle();
    v = rdata;
  endtask

  task automatic wr(bit [2:0] a, bit [31:0] d);
    step(1, 1, a, d, 0, 0, 0, 0, 0);
    idle();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 irq after reset", 64'(irq), 0);
    check("R1 rdata after reset", 64'(rdata), 0);
    rst_n = 1'b1;
    rd(3, v); check("R1 status", 64'(v), 0);
    rd(5, v); check("R1 enable", 64'(v), 0);
    rd(0, v); check("R1 addr lo", 64'(v), 0);

    // R2 device event, not enabled
    step(0, 0, 0, 0, 1, 0, 0, 0, 0); idle();
    check("R6 disabled cause no irq", 64'(irq), 0);
    rd(3, v); check("R2 dev cause", 64'(v), 1);

    // R3 enable set, zero bits ignored
    wr(5, 32'h0); rd(5, v); check("R3 zero write", 64'(v), 0);
    wr(5, 32'h1); rd(5, v); check("R3 enable bit0", 64'(v), 1);
    check("R6 irq asserted", 64'(irq), 1);

    // R8 first error capture
    step(0, 0, 0, 0, 0, 1, 64'hA5A5_0001_1234_5678, 0, 0); idle();
    rd(3, v); check("R2 both causes", 64'(v), 3);
    rd(0, v); check("R8 addr lo", 64'(v), 32'h1234_5678);
    rd(1, v); check("R8 addr hi", 64'(v), 32'hA5A5_0001);

    // R9 later error does not overwrite
    step(0, 0, 0, 0, 0, 1, 64'hDEAD_BEEF_0BAD_F00D, 0, 0); idle();
    rd(0, v); check("R9 addr lo held", 64'(v), 32'h1234_5678);
    rd(1, v); check("R9 addr hi held", 64'(v), 32'hA5A5_0001);

    // R4 selective clear
    wr(7, 32'h1); rd(3, v); check("R4 clear bit0", 64'(v), 2);
    wr(5, 32'h2);
    check("R6 irq via bus error", 64'(irq), 1);

    // R5 clear write and new error in one cycle
    step(1, 1, 7, 32'h3, 0, 1, 64'h0000_0007_CAFE_0042, 0, 0); idle();
    rd(3, v); check("R5 error survives clear", 64'(v), 2);
    rd(0, v); check("R8 recapture on clear", 64'(v), 32'hCAFE_0042);
    rd(1, v); check("R8 recapture hi", 64'(v), 32'h0000_0007);

    // R7 busy status read ignored, idle one clears
    step(0, 0, 0, 0, 0, 0, 0, 1, 8'h80); idle();
    rd(3, v); check("R7 busy read no effect", 64'(v), 2);
    step(0, 0, 0, 0, 0, 0, 0, 1, 8'h50); idle();
    rd(3, v); check("R7 idle read clears", 64'(v), 0);
    check("R6 irq dropped", 64'(irq), 0);

    // R5 status-read clear vs device event
    step(0, 0, 0, 0, 1, 0, 0, 1, 8'h00); idle();
    rd(3, v); check("R5 dev survives idle read", 64'(v), 1);

    // R10 read-only writes ignored, unmapped reads zero
    wr(3, 32'h0); wr(0, 32'hFFFF_FFFF);
    rd(3, v); check("R10 status write ignored", 64'(v), 1);
    rd(0, v); check("R10 addr write ignored", 64'(v), 32'hCAFE_0042);
    rd(2, v); check("R10 index 2 zero", 64'(v), 0);
    rd(7, v); check("R10 index 7 zero", 64'(v), 0);
    rd(6, v); check("R10 index 6 zero", 64'(v), 0);
    repeat (3) idle();
    check("R10 rdata held", 64'(rdata), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule